// File: doc/BRIEF.md
# Dual-Byte Comma Word Aligner

This block sits behind a deserializer that delivers 20 bits per byte clock. Each word carries two 10-bit 8b/10b code groups, and the word boundaries fall wherever the deserializer happened to start, so they need not match the code-group boundaries. The block keeps the previous word and joins it with the current one into a 40-bit window. In that window it looks for the seven-bit comma that begins a K28.5 character, in either running-disparity form. From the position of the comma it picks a bit offset and then emits 20-bit words taken from the window at that offset. The comma therefore always opens the first code group of the output word.

An enable input controls realignment. While the enable is high, every comma the block finds sets the offset again and pulses the comma-seen output. While it is low, the offset stays where it is, commas are passed through as ordinary data, and comma-seen stays low. A sticky valid flag rises with the first comma-seen after reset and tells the downstream logic that the output words are on code-group boundaries from then on.

Top module: `dual_comma_aligner`

## Requirements
- R1: While rst_n is low, aligned_word, comma_seen and word_valid are all zero.
- R2: Bit i of the window arrives before bit i+1. The previous word takes window bits 0-19 and the current word takes bits 20-39. A comma at position p means window bits p..p+6 hold 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0. It is detected for every p from 0 to 19, and aligned_word bits 0..6 then hold the comma.
- R3: Once a comma at position p has been taken, aligned_word holds window bits p..p+19 on that edge and on every later edge until the offset changes. The output is a contiguous continuation of the serial stream.
- R4: Take a comma at bit q (0-19) of the word sampled at edge n. comma_seen is high right after edge n+1, in the same cycle as the aligned word whose bits 0..6 hold that comma, and it is low in the cycles just before and after.
- R5: When several commas lie in one window, the one at the lowest position sets the offset.
- R6: While align_en is high, every comma detected sets the offset again, even when an offset is already in use.
- R7: While align_en is low at an edge, the offset is kept and any comma at that edge is ignored. The output keeps the old offset.
- R8: word_valid is low from reset until the first comma_seen and stays high after it.
- R9: comma_seen is high only after an edge at which align_en was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 20 | Raw deserialized word, bit 0 received first |
| align_en | input | 1 | Allows commas to set the offset |
| aligned_word | output | 20 | Word re-framed at the current offset |
| comma_seen | output | 1 | Pulse: a comma was taken and opens aligned_word |
| word_valid | output | 1 | Sticky flag: output is aligned |

## Verification
A comma that starts at bit q of the word presented before edge n is scanned at edge n+1. That is the edge where the word becomes the lower half of the window. Both comma_seen and the first aligned word are due right after edge n+1. The output due after edge n+1+j is the 20 stream bits that start 20*j bits past the comma. The bench computes each of these positions from the comma's global bit index. It drives inputs on the falling edge and samples one nanosecond after every rising edge, so every expected value belongs to exactly one edge.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

   // which comma polarities the scanner accepts
   typedef enum logic [0:0] {
      MATCH_ONE_POLARITY = 1'b0,
      MATCH_BOTH         = 1'b1
   } mark_mode_e;

   localparam int unsigned DEF_GROUP_W = 10;
   localparam int unsigned DEF_GROUPS  = 2;
   localparam int unsigned DEF_MARK_W  = 7;
   // bit 0 is the earliest serial bit: 0,0,1,1,1,1,1
   localparam logic [DEF_MARK_W-1:0] DEF_MARK_PAT = 7'b1111100;

endpackage

// File: rtl/comma_scan.sv
module comma_scan
   import aligner_pkg::*;
#(
   parameter int unsigned WORD_W   = 20,
   parameter int unsigned MARK_W   = 7,
   parameter logic [MARK_W-1:0] MARK_PAT = 7'b1111100,
   parameter mark_mode_e  MODE     = MATCH_BOTH,
   localparam int unsigned WIN_W   = 2 * WORD_W,
   localparam int unsigned OFF_W   = $clog2(WORD_W)
) (
   input  logic [WIN_W-1:0] win,
   output logic             hit,
   output logic [OFF_W-1:0] pos
);

   logic [WORD_W-1:0] hits;

   for (genvar p = 0; p < WORD_W; p++) begin : g_pos
      logic [MARK_W-1:0] slice;
      assign slice = win[p +: MARK_W];
      if (MODE == MATCH_BOTH) begin : g_both
         assign hits[p] = (slice == MARK_PAT) || (slice == ~MARK_PAT);
      end else begin : g_one
         assign hits[p] = (slice == MARK_PAT);
      end
   end

   // lowest matching position wins
   always_comb begin
      hit = |hits;
      pos = '0;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         if (hits[i]) pos = OFF_W'(i);
      end
   end

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
   parameter int unsigned WORD_W = 20,
   localparam int unsigned WIN_W = 2 * WORD_W,
   localparam int unsigned OFF_W = $clog2(WORD_W)
) (
   input  logic [WIN_W-1:0]  win,
   input  logic [OFF_W-1:0]  sel,
   output logic [WORD_W-1:0] word
);

   logic [WIN_W-1:0] shifted;

   always_comb begin
      shifted = win >> sel;
      word    = shifted[WORD_W-1:0];
   end

endmodule

// File: rtl/align_state.sv
module align_state #(
   parameter int unsigned WORD_W = 20,
   localparam int unsigned OFF_W = $clog2(WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [OFF_W-1:0] new_off,
   output logic [OFF_W-1:0] off_q,
   output logic             locked_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q    <= '0;
         locked_q <= 1'b0;
      end else if (take) begin
         off_q    <= new_off;
         locked_q <= 1'b1;
      end
   end

endmodule

// File: rtl/dual_comma_aligner.sv
module dual_comma_aligner
   import aligner_pkg::*;
#(
   parameter int unsigned GROUP_W  = DEF_GROUP_W,
   parameter int unsigned GROUPS   = DEF_GROUPS,
   parameter int unsigned MARK_W   = DEF_MARK_W,
   parameter logic [MARK_W-1:0] MARK_PAT = DEF_MARK_PAT,
   parameter mark_mode_e  MODE     = MATCH_BOTH,
   localparam int unsigned WORD_W  = GROUP_W * GROUPS,
   localparam int unsigned WIN_W   = 2 * WORD_W,
   localparam int unsigned OFF_W   = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              align_en,
   output logic [WORD_W-1:0] aligned_word,
   output logic              comma_seen,
   output logic              word_valid
);

   // elaboration-time parameter checks
   if (MARK_W < 2 || MARK_W > GROUP_W) begin : g_bad_mark
      $error("comma width must lie between 2 and the code-group width");
   end
   if (GROUPS < 1) begin : g_bad_groups
      $error("at least one code group per word is required");
   end

   logic [WORD_W-1:0] prev_q;
   logic [WIN_W-1:0]  win;
   logic              hit;
   logic [OFF_W-1:0]  pos;
   logic              take;
   logic [OFF_W-1:0]  off_q;
   logic [OFF_W-1:0]  sel;
   logic [WORD_W-1:0] nxt_word;

   assign win  = {rx_word, prev_q};
   assign take = align_en & hit;
   assign sel  = take ? pos : off_q;

   comma_scan #(
      .WORD_W   (WORD_W),
      .MARK_W   (MARK_W),
      .MARK_PAT (MARK_PAT),
      .MODE     (MODE)
   ) u_scan (
      .win (win),
      .hit (hit),
      .pos (pos)
   );

   word_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .win  (win),
      .sel  (sel),
      .word (nxt_word)
   );

   align_state #(
      .WORD_W (WORD_W)
   ) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .new_off  (pos),
      .off_q    (off_q),
      .locked_q (word_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q       <= '0;
         aligned_word <= '0;
         comma_seen   <= 1'b0;
      end else begin
         prev_q       <= rx_word;
         aligned_word <= nxt_word;
         comma_seen   <= take;
      end
   end

endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
   parameter int unsigned WORD_W = 20,
   parameter int unsigned MARK_W = 7,
   parameter logic [MARK_W-1:0] MARK_PAT = 7'b1111100,
   localparam int unsigned OFF_W = $clog2(WORD_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              align_en,
   input logic [WORD_W-1:0] aligned_word,
   input logic              comma_seen,
   input logic              word_valid,
   input logic [OFF_W-1:0]  off_q
);

   AST_SEEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      comma_seen |-> $past(align_en)); // R9

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> word_valid); // R8

   AST_SEEN_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      comma_seen |-> word_valid); // R8

   AST_FROZEN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      !align_en |=> $stable(off_q)); // R7

   AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      off_q < OFF_W'(WORD_W)); // R3

   AST_COMMA_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      comma_seen |-> (aligned_word[MARK_W-1:0] == MARK_PAT ||
                      aligned_word[MARK_W-1:0] == ~MARK_PAT)); // R2

endmodule

bind dual_comma_aligner aligner_checker #(
   .WORD_W   (WORD_W),
   .MARK_W   (MARK_W),
   .MARK_PAT (MARK_PAT)
) u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .align_en     (align_en),
   .aligned_word (aligned_word),
   .comma_seen   (comma_seen),
   .word_valid   (word_valid),
   .off_q        (off_q)
);

// File: tb/test_dual_comma_aligner.sv
module test_dual_comma_aligner;

   localparam int W  = 20;
   localparam int NW = 10;
   localparam int SB = W * NW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] rx_word = '0;
   logic         align_en = 1'b0;
   logic [W-1:0] aligned_word;
   logic         comma_seen;
   logic         word_valid;

   int checks = 0;
   int errors = 0;
   logic [SB-1:0] stream;

   always #2 clk = ~clk;

   dual_comma_aligner i_dual_comma_aligner (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_word      (rx_word),
      .align_en     (align_en),
      .aligned_word (aligned_word),
      .comma_seen   (comma_seen),
      .word_valid   (word_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // alternating background never holds a comma; comma bit j is 0 for j<2
   task automatic put_comma(input int s, input bit pol);
      for (int j = 0; j < 7; j++) stream[s + j] = pol ^ (j >= 2);
   endtask

   task automatic run_trial(input int s1, input bit has1, input int s2, input bit has2,
                            input bit pol, input int en_cut, input string tag);
      int  k1, k2, act_s, act_e;
      bit  seen;
      for (int i = 0; i < SB; i++) stream[i] = i[0];
      if (has1) put_comma(s1, pol);
      if (has2) put_comma(s2, !pol);
      k1 = s1 / W + 1;
      k2 = s2 / W + 1;
      seen = 0; act_s = 0; act_e = 0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(aligned_word == '0, "R1 word", 32'(aligned_word), 0);
      chk(comma_seen == 1'b0, "R1 seen", 32'(comma_seen), 0);
      chk(word_valid == 1'b0, "R1 valid", 32'(word_valid), 0);
      rst_n = 1'b1;
      for (int w = 0; w < NW; w++) begin
         bit en, d1, d2, exp_det;
         @(negedge clk);
         en = (w < en_cut);
         rx_word  = stream[w*W +: W];
         align_en = en;
         @(posedge clk);
         #1;
         d1 = has1 && en && (w == k1);
         d2 = has2 && en && (w == k2);
         exp_det = d1 | d2;
         if (d1 && d2) begin act_s = (s1 < s2) ? s1 : s2; act_e = w; seen = 1; end  // R5
         else if (d1) begin act_s = s1; act_e = w; seen = 1; end
         else if (d2) begin act_s = s2; act_e = w; seen = 1; end                  // R6
         // R4 timing, R9 enable gating, R7 ignore while disabled
         chk(comma_seen == exp_det, {tag, " R4/R9 comma_seen"}, 32'(comma_seen), 32'(exp_det));
         chk(word_valid == seen, {tag, " R8 word_valid"}, 32'(word_valid), 32'(seen));
         if (seen) begin
            logic [W-1:0] exp_w;
            exp_w = stream[act_s + W*(w - act_e) +: W];
            chk(aligned_word == exp_w, {tag, " R3 aligned_word"}, 32'(aligned_word), 32'(exp_w));
         end
         if (exp_det) begin
            bit lead_ok;
            lead_ok = (aligned_word[6:0] == 7'b1111100) || (aligned_word[6:0] == 7'b0000011);
            chk(lead_ok, {tag, " R2 comma leads"}, 32'(aligned_word[6:0]), 32'h7c);
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog R1 actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R2 R3 R4: every offset, both polarities
      for (int pol = 0; pol < 2; pol++)
         for (int q = 0; q < W; q++)
            run_trial(2*W + q, 1, 0, 0, pol[0], NW, "sweep");
      // R5: two commas in one window, lowest wins
      run_trial(3*W + 2, 1, 3*W + 11, 1, 0, NW, "R5 low-first");
      run_trial(3*W + 12, 1, 3*W + 1, 1, 1, NW, "R5 low-second");
      // R6: realign while enabled
      run_trial(1*W + 4, 1, 5*W + 15, 1, 0, NW, "R6 realign");
      run_trial(1*W + 7, 1, 4*W + 7, 1, 1, NW, "R6 same offset");
      // R7: freeze after disabling
      run_trial(1*W + 4, 1, 5*W + 15, 1, 0, 4, "R7 freeze");
      run_trial(1*W + 16, 1, 6*W + 2, 1, 1, 3, "R7 freeze2");
      // R8 R9: never enabled
      run_trial(2*W + 3, 1, 0, 0, 0, 0, "R9 disabled");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule